// File: doc/BRIEF.md
# Video Control Register Bank

This block is the control and status register bank of a display processor. It sits behind the address decoder's I/O window. It holds interrupt enable and pending state, display and drawing control, four brightness levels, a frame-cycle count, a pair of column-table indices and four object-control words. It also holds eight packed palettes (four for backgrounds, four for objects) and a backdrop colour. Its outputs are a registered interrupt request and the stored fields, which go to the display and drawing engines. Those engines return their busy flags, scan-ready, frame clock and vertical position through status input ports.

The bank is organised in halfwords. A byte, halfword or word access is split by an access stage into one or two halfword slots, each with a lane mask. The registers then apply their own width masks to the slots. A debug flag changes how byte writes are applied. In normal operation a byte write is widened to a whole halfword. With the debug flag set, a byte write touches only the addressed lane.

Top module: `vid_ctrl_regs`

## Requirements
- R1: After reset every halfword of the window reads zero, except the version halfword at byte offset 0x44, and `irq_o` is low. With all status inputs low, the status halfwords also read zero.
- R2: A halfword write stores only each register's valid bits, and a read returns those bits. The masks are: interrupt enable (offset 0x02) 0xE01F, brightness 0x24/0x26/0x28/0x2A 0x00FF, frame cycle (0x2E) 0x000F, column index (0x30) 0xFFFF, object control 0x48/0x4A/0x4C/0x4E 0x03FF, and backdrop (0x70) 0x0003.
- R3: `size_i`=2 selects a word access. It acts on the halfword at the address (bits 15:0) and on the halfword at address+2 (bits 31:16), for both writes and reads.
- R4: With `dbg_i`=0, a byte write (`size_i`=0) writes a whole halfword. At an odd address the data byte goes to bits 15:8 and bits 7:0 become zero. At an even address the data byte goes to bits 7:0 and bits 15:8 become zero.
- R5: With `dbg_i`=1, a byte write changes only the addressed lane and the other lane keeps its value.
- R6: A byte read returns the addressed lane in `rdata_o[7:0]`, zero-extended. Unmapped offsets, the control offsets 0x22 and 0x42, and the clear offset 0x04 read zero, and a write to an unmapped offset has no effect.
- R7: The pending halfword (0x00) gains the bits asserted on `int_set_i`. A write to offset 0x04 clears the pending bits that are set in the data. When a bit is set and cleared in the same cycle, the set wins.
- R8: `irq_o` is the OR over all bits of pending AND enable, registered one cycle after that state. It deasserts one cycle after pending clears.
- R9: Display status (0x20) reads lock at bit 10, sync enable at 9, refresh enable at 8, `disp_stat_i[5:0]` at bits 7:2 and display enable at bit 1. The writable bits come from display control (0x22): bits 10..8 are in the upper lane and bit 1 in the lower lane.
- R10: Drawing status (0x40) reads `draw_stat_i[8]` at bit 15, `draw_stat_i[7:3]` at 12:8, `draw_stat_i[2:0]` at 4:2 and drawing enable at bit 1. Drawing control (0x42) stores the compare value from bits 12:8 (`sb_cmp_o`) and the enable from bit 1.
- R11: Palettes (0x60..0x6E) store data bits 7:2 and read them back with bits 1:0 zero. A write whose lower lane is masked (debug byte at an odd address) leaves the palette unchanged.
- R12: Offset 0x44 reads the constant version 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 write, 0 read |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| dbg_i | input | 1 | Debug byte-write mode |
| addr_i | input | 8 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when not reading |
| int_set_i | input | 16 | Pending-set pulses |
| disp_stat_i | input | 6 | Frame clock, scan ready, right/left buffer 1 busy, right/left buffer 0 busy (bit 5..0) |
| draw_stat_i | input | 9 | Match flag, vertical count[4:0], overtime, buffer 1 busy, buffer 0 busy (bit 8..0) |
| irq_o | output | 1 | Interrupt request |
| disp_en_o | output | 1 | Display enable |
| refresh_en_o | output | 1 | Memory refresh enable |
| sync_en_o | output | 1 | Sync/servo enable |
| cta_lock_o | output | 1 | Column table lock |
| draw_en_o | output | 1 | Drawing enable |
| sb_cmp_o | output | 5 | Vertical compare value |
| brt_o | output | 32 | Four 8-bit brightness levels |
| frmcyc_o | output | 4 | Frame cycle count |
| cta_left_o | output | 8 | Left column table index |
| cta_right_o | output | 8 | Right column table index |
| spt_o | output | 40 | Four 10-bit object-control words |
| bg_plt_o | output | 24 | Four 6-bit background palettes |
| obj_plt_o | output | 24 | Four 6-bit object palettes |
| bkcol_o | output | 2 | Backdrop colour |

## Verification
The reset value of every halfword is swept. Every writable register is written with all ones and with an alternating pattern, so that each width mask shows up distinctly. Byte writes are tried at odd and even addresses in both modes on a register that has two populated lanes, which separates widening from lane-preserving. Word accesses use register pairs whose halves differ, which exposes a swapped or dropped half. All 64 display-status input patterns and every vertical-count value combined with each drawing flag are read back, which catches a mis-placed bit. The interrupt path is stepped edge by edge, which separates a registered request from a combinational one and tests the set-over-clear case.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int AW      = 8;
  localparam int IW      = AW - 1;
  localparam int NUM_HW  = 1 << IW;
  localparam int NUM_BRT = 4;
  localparam int NUM_SPT = 4;
  localparam int SPT_W   = 10;
  localparam int NUM_PLT = 4;
  localparam int PLT_W   = 6;
  localparam int SB_W    = 5;
  localparam int FRM_W   = 4;
  localparam int BK_W    = 2;
  localparam int DS_W    = 6;
  localparam int XS_W    = 9;
  localparam logic [15:0] ENB_MASK = 16'hE01F;

  // halfword indices within the window
  localparam logic [IW-1:0] HI_PND   = IW'(7'h00);
  localparam logic [IW-1:0] HI_ENB   = IW'(7'h01);
  localparam logic [IW-1:0] HI_CLR   = IW'(7'h02);
  localparam logic [IW-1:0] HI_DSTAT = IW'(7'h10);
  localparam logic [IW-1:0] HI_DCTL  = IW'(7'h11);
  localparam logic [IW-1:0] HI_BRT0  = IW'(7'h12);
  localparam logic [IW-1:0] HI_FRM   = IW'(7'h17);
  localparam logic [IW-1:0] HI_CTA   = IW'(7'h18);
  localparam logic [IW-1:0] HI_XSTAT = IW'(7'h20);
  localparam logic [IW-1:0] HI_XCTL  = IW'(7'h21);
  localparam logic [IW-1:0] HI_VER   = IW'(7'h22);
  localparam logic [IW-1:0] HI_SPT0  = IW'(7'h24);
  localparam logic [IW-1:0] HI_PLT0  = IW'(7'h30);
  localparam logic [IW-1:0] HI_BKCOL = IW'(7'h38);

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

  typedef struct packed {
    logic          vld;
    logic [IW-1:0] idx;
    logic [1:0]    be;
    logic [15:0]   d;
  } hw_wr_t;

  typedef struct packed {
    logic                             lock;
    logic                             synce;
    logic                             re;
    logic                             disp;
    logic                             xpen;
    logic [SB_W-1:0]                  sbcmp;
    logic [NUM_BRT-1:0][7:0]          brt;
    logic [FRM_W-1:0]                 frm;
    logic [7:0]                       cta_l;
    logic [7:0]                       cta_r;
    logic [NUM_SPT-1:0][SPT_W-1:0]    spt;
    logic [BK_W-1:0]                  bkcol;
  } ctl_t;
endpackage

// File: rtl/vcr_access.sv
module vcr_access
  import vcr_pkg::*;
(
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic          dbg_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output hw_wr_t        wr_o [2]
);
  logic [IW-1:0] idx0;
  logic          wr;
  assign idx0 = addr_i[AW-1:1];
  assign wr   = req_i && we_i;

  always_comb begin
    wr_o[0] = '{vld: wr, idx: idx0, be: 2'b11, d: wdata_i[15:0]};
    wr_o[1] = '{vld: 1'b0, idx: idx0 + 1'b1, be: 2'b11, d: wdata_i[31:16]};
    unique case (size_i)
      SZ_BYTE: begin
        wr_o[0].d = addr_i[0] ? {wdata_i[7:0], 8'h00} : {8'h00, wdata_i[7:0]};
        if (dbg_i) wr_o[0].be = addr_i[0] ? 2'b10 : 2'b01;
      end
      SZ_WORD: wr_o[1].vld = wr;
      default: ;
    endcase
  end
endmodule

// File: rtl/vcr_int_unit.sv
module vcr_int_unit
  import vcr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  hw_wr_t      wr_i [2],
  input  logic [15:0] set_i,
  output logic [15:0] pnd_o,
  output logic [15:0] en_o,
  output logic        irq_o
);
  logic [15:0] pnd_q, en_q, en_n, clr;
  logic        irq_q;

  always_comb begin
    en_n = en_q;
    clr  = '0;
    for (int s = 0; s < 2; s++) begin
      if (wr_i[s].vld && wr_i[s].idx == HI_ENB) begin
        if (wr_i[s].be[0]) en_n[7:0]  = wr_i[s].d[7:0]  & ENB_MASK[7:0];
        if (wr_i[s].be[1]) en_n[15:8] = wr_i[s].d[15:8] & ENB_MASK[15:8];
      end
      if (wr_i[s].vld && wr_i[s].idx == HI_CLR) clr = clr | wr_i[s].d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnd_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      pnd_q <= (pnd_q & ~clr) | set_i;
      en_q  <= en_n;
      irq_q <= |(pnd_q & en_q);
    end
  end

  assign pnd_o = pnd_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/vcr_plt_reg.sv
module vcr_plt_reg
  import vcr_pkg::*;
#(
  parameter logic [IW-1:0] IDX = HI_PLT0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  hw_wr_t           wr_i [2],
  output logic [PLT_W-1:0] ent_o
);
  logic [PLT_W-1:0] ent_q, ent_n;

  always_comb begin
    ent_n = ent_q;
    for (int s = 0; s < 2; s++)
      if (wr_i[s].vld && wr_i[s].idx == IDX && wr_i[s].be[0])
        ent_n = wr_i[s].d[7:2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= '0;
    else         ent_q <= ent_n;
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/vid_ctrl_regs.sv
module vid_ctrl_regs
  import vcr_pkg::*;
#(
  parameter logic [15:0] VERSION = 16'd2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [1:0]                 size_i,
  input  logic                       dbg_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  input  logic [15:0]                int_set_i,
  input  logic [DS_W-1:0]            disp_stat_i,
  input  logic [XS_W-1:0]            draw_stat_i,
  output logic                       irq_o,
  output logic                       disp_en_o,
  output logic                       refresh_en_o,
  output logic                       sync_en_o,
  output logic                       cta_lock_o,
  output logic                       draw_en_o,
  output logic [SB_W-1:0]            sb_cmp_o,
  output logic [NUM_BRT*8-1:0]       brt_o,
  output logic [FRM_W-1:0]           frmcyc_o,
  output logic [7:0]                 cta_left_o,
  output logic [7:0]                 cta_right_o,
  output logic [NUM_SPT*SPT_W-1:0]   spt_o,
  output logic [NUM_PLT*PLT_W-1:0]   bg_plt_o,
  output logic [NUM_PLT*PLT_W-1:0]   obj_plt_o,
  output logic [BK_W-1:0]            bkcol_o
);
  localparam int NPR = 2 * NUM_PLT;

  hw_wr_t           wr [2];
  logic [15:0]      int_pnd, int_en;
  logic [PLT_W-1:0] plt_ent [NPR];
  ctl_t             ctl_q, ctl_n;
  logic [15:0]      view [NUM_HW];
  logic [IW-1:0]    ridx0, ridx1;
  logic [15:0]      h0, h1;

  vcr_access u_access (
    .req_i(req_i), .we_i(we_i), .size_i(size_i), .dbg_i(dbg_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wr_o(wr)
  );

  vcr_int_unit u_int (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .set_i(int_set_i),
    .pnd_o(int_pnd), .en_o(int_en), .irq_o(irq_o)
  );

  for (genvar i = 0; i < NPR; i++) begin : g_plt
    vcr_plt_reg #(.IDX(IW'(HI_PLT0 + i))) u_plt (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .ent_o(plt_ent[i])
    );
    if (i < NUM_PLT) begin : g_bg
      assign bg_plt_o[i*PLT_W +: PLT_W] = plt_ent[i];
    end else begin : g_obj
      assign obj_plt_o[(i-NUM_PLT)*PLT_W +: PLT_W] = plt_ent[i];
    end
  end

  // per-lane updates of the plain registers
  always_comb begin
    ctl_n = ctl_q;
    for (int s = 0; s < 2; s++) begin
      if (wr[s].vld) begin
        if (wr[s].idx == HI_DCTL) begin
          if (wr[s].be[1]) {ctl_n.lock, ctl_n.synce, ctl_n.re} = wr[s].d[10:8];
          if (wr[s].be[0]) ctl_n.disp = wr[s].d[1];
        end
        if (wr[s].idx == HI_XCTL) begin
          if (wr[s].be[1]) ctl_n.sbcmp = wr[s].d[8 +: SB_W];
          if (wr[s].be[0]) ctl_n.xpen = wr[s].d[1];
        end
        for (int i = 0; i < NUM_BRT; i++)
          if (wr[s].idx == IW'(HI_BRT0 + i) && wr[s].be[0]) ctl_n.brt[i] = wr[s].d[7:0];
        if (wr[s].idx == HI_FRM && wr[s].be[0]) ctl_n.frm = wr[s].d[FRM_W-1:0];
        if (wr[s].idx == HI_CTA) begin
          if (wr[s].be[1]) ctl_n.cta_r = wr[s].d[15:8];
          if (wr[s].be[0]) ctl_n.cta_l = wr[s].d[7:0];
        end
        for (int i = 0; i < NUM_SPT; i++) begin
          if (wr[s].idx == IW'(HI_SPT0 + i)) begin
            if (wr[s].be[1]) ctl_n.spt[i][SPT_W-1:8] = wr[s].d[SPT_W-1:8];
            if (wr[s].be[0]) ctl_n.spt[i][7:0] = wr[s].d[7:0];
          end
        end
        if (wr[s].idx == HI_BKCOL && wr[s].be[0]) ctl_n.bkcol = wr[s].d[BK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_n;
  end

  // read view of the window
  always_comb begin
    for (int i = 0; i < NUM_HW; i++) view[i] = '0;
    view[HI_PND]   = int_pnd;
    view[HI_ENB]   = int_en;
    view[HI_DSTAT] = {5'b0, ctl_q.lock, ctl_q.synce, ctl_q.re, disp_stat_i, ctl_q.disp, 1'b0};
    for (int i = 0; i < NUM_BRT; i++) view[IW'(HI_BRT0 + i)] = {8'h00, ctl_q.brt[i]};
    view[HI_FRM]   = 16'(ctl_q.frm);
    view[HI_CTA]   = {ctl_q.cta_r, ctl_q.cta_l};
    view[HI_XSTAT] = {draw_stat_i[8], 2'b0, draw_stat_i[7:3], 3'b0, draw_stat_i[2:0],
                      ctl_q.xpen, 1'b0};
    view[HI_VER]   = VERSION;
    for (int i = 0; i < NUM_SPT; i++) view[IW'(HI_SPT0 + i)] = 16'(ctl_q.spt[i]);
    for (int i = 0; i < NPR; i++) view[IW'(HI_PLT0 + i)] = {8'h00, plt_ent[i], 2'b00};
    view[HI_BKCOL] = 16'(ctl_q.bkcol);
  end

  assign ridx0 = addr_i[AW-1:1];
  assign ridx1 = ridx0 + 1'b1;
  assign h0    = view[ridx0];
  assign h1    = view[ridx1];

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (size_i)
        SZ_BYTE: rdata_o = {24'h0, addr_i[0] ? h0[15:8] : h0[7:0]};
        SZ_WORD: rdata_o = {h1, h0};
        default: rdata_o = {16'h0, h0};
      endcase
    end
  end

  assign disp_en_o    = ctl_q.disp;
  assign refresh_en_o = ctl_q.re;
  assign sync_en_o    = ctl_q.synce;
  assign cta_lock_o   = ctl_q.lock;
  assign draw_en_o    = ctl_q.xpen;
  assign sb_cmp_o     = ctl_q.sbcmp;
  assign brt_o        = ctl_q.brt;
  assign frmcyc_o     = ctl_q.frm;
  assign cta_left_o   = ctl_q.cta_l;
  assign cta_right_o  = ctl_q.cta_r;
  assign spt_o        = ctl_q.spt;
  assign bkcol_o      = ctl_q.bkcol;
endmodule

// File: rtl/vid_ctrl_regs_chk.sv
module vid_ctrl_regs_chk
  import vcr_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [1:0]      size_i,
  input logic            dbg_i,
  input logic [AW-1:0]   addr_i,
  input logic [31:0]     rdata_o,
  input logic [15:0]     int_set_i,
  input logic [DS_W-1:0] disp_stat_i,
  input logic            irq_o,
  input logic [FRM_W-1:0] frmcyc_o,
  input logic [BK_W-1:0] bkcol_o,
  input logic [15:0]     pnd_i,
  input logic [15:0]     en_i
);
  assert_irq_registered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |($past(pnd_i & en_i)));

  assert_pnd_rise_from_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pnd_i & ~$past(pnd_i) & ~$past(int_set_i)) == 16'h0);

  assert_odd_byte_widened_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !dbg_i && size_i == SZ_BYTE && addr_i == {HI_FRM, 1'b1})
    |=> frmcyc_o == '0);

  assert_dbg_lane_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && dbg_i && size_i == SZ_BYTE && addr_i == {HI_BKCOL, 1'b1})
    |=> $stable(bkcol_o));

  assert_dstat_inputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == SZ_HALF && addr_i == {HI_DSTAT, 1'b0})
    |-> rdata_o[7:2] == disp_stat_i);

  assert_unmapped_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == SZ_HALF && addr_i == AW'(8'h32))
    |-> rdata_o == 32'h0);
endmodule

bind vid_ctrl_regs vid_ctrl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
  .dbg_i(dbg_i), .addr_i(addr_i), .rdata_o(rdata_o), .int_set_i(int_set_i),
  .disp_stat_i(disp_stat_i), .irq_o(irq_o), .frmcyc_o(frmcyc_o), .bkcol_o(bkcol_o),
  .pnd_i(int_pnd), .en_i(int_en)
);

// File: tb/vid_ctrl_regs_tb.sv
`timescale 1ns/1ps
module vid_ctrl_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, dbg_i = 1'b0;
  logic [1:0]  size_i = 2'd1;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] int_set_i = '0;
  logic [5:0]  disp_stat_i = '0;
  logic [8:0]  draw_stat_i = '0;
  logic        irq_o, disp_en_o, refresh_en_o, sync_en_o, cta_lock_o, draw_en_o;
  logic [4:0]  sb_cmp_o;
  logic [31:0] brt_o;
  logic [3:0]  frmcyc_o;
  logic [7:0]  cta_left_o, cta_right_o;
  logic [39:0] spt_o;
  logic [23:0] bg_plt_o, obj_plt_o;
  logic [1:0]  bkcol_o;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vid_ctrl_regs u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic dbg, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; size_i = sz; dbg_i = dbg; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; dbg_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; size_i = sz;
    #1 v = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  function automatic logic [15:0] wmask(input int hi);
    if (hi == 1) return 16'hE01F;
    if (hi >= 8'h12 && hi <= 8'h15) return 16'h00FF;
    if (hi == 8'h17) return 16'h000F;
    if (hi == 8'h18) return 16'hFFFF;
    if (hi >= 8'h24 && hi <= 8'h27) return 16'h03FF;
    if (hi >= 8'h30 && hi <= 8'h37) return 16'h00FC;
    if (hi == 8'h38) return 16'h0003;
    return 16'h0000;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 / R12: reset sweep of the whole window
    chk("R1 irq_o at reset", {31'h0, irq_o}, 32'h0);
    for (int h = 0; h < 128; h++) begin
      rd(8'(h * 2), 2'd1, v);
      chk(h == 8'h22 ? "R12 version" : "R1 reset read", v, h == 8'h22 ? 32'h2 : 32'h0);
    end

    // R2: width masks, two patterns
    for (int h = 0; h < 128; h++) begin
      if (wmask(h) != 16'h0) begin
        wr(8'(h * 2), 2'd1, 1'b0, 32'hFFFF);
        rd(8'(h * 2), 2'd1, v);
        chk("R2 all-ones mask", v, {16'h0, wmask(h)});
        wr(8'(h * 2), 2'd1, 1'b0, 32'hA5C3);
        rd(8'(h * 2), 2'd1, v);
        chk("R2 pattern mask", v, {16'h0, 16'hA5C3 & wmask(h)});
      end
    end

    // R3: word accesses
    wr(8'h24, 2'd2, 1'b0, 32'h1234_00AB);
    rd(8'h24, 2'd2, v);
    chk("R3 word brightness", v, 32'h0034_00AB);
    chk("R3 brt_o", brt_o[15:0], 32'h34AB);
    wr(8'h48, 2'd2, 1'b0, 32'h0155_02AA);
    rd(8'h48, 2'd2, v);
    chk("R3 word object control", v, 32'h0155_02AA);
    wr(8'h30, 2'd1, 1'b0, 32'h0000_BEEF);
    rd(8'h30, 2'd2, v);
    chk("R3 word read into unmapped half", v, 32'h0000_BEEF);

    // R4: normal byte write widens
    wr(8'h31, 2'd0, 1'b0, 32'h5A);
    rd(8'h30, 2'd1, v);
    chk("R4 odd byte widened", v, 32'h5A00);
    chk("R4 cta_left_o", {24'h0, cta_left_o}, 32'h0);
    wr(8'h30, 2'd0, 1'b0, 32'h77);
    rd(8'h30, 2'd1, v);
    chk("R4 even byte widened", v, 32'h0077);
    wr(8'h2F, 2'd0, 1'b0, 32'h0F);
    chk("R4 odd byte zeroes frame cycle", {28'h0, frmcyc_o}, 32'h0);

    // R5: debug byte write keeps other lane
    wr(8'h30, 2'd1, 1'b0, 32'hBEEF);
    wr(8'h31, 2'd0, 1'b1, 32'h5A);
    rd(8'h30, 2'd1, v);
    chk("R5 debug upper lane", v, 32'h5AEF);
    wr(8'h30, 2'd0, 1'b1, 32'h12);
    rd(8'h30, 2'd1, v);
    chk("R5 debug lower lane", v, 32'h5A12);
    chk("R5 cta_right_o", {24'h0, cta_right_o}, 32'h5A);
    wr(8'h70, 2'd1, 1'b0, 32'h2);
    wr(8'h71, 2'd0, 1'b1, 32'hFF);
    chk("R5 debug upper lane on backdrop", {30'h0, bkcol_o}, 32'h2);

    // R6: byte reads and unmapped
    rd(8'h30, 2'd0, v); chk("R6 byte read even", v, 32'h12);
    rd(8'h31, 2'd0, v); chk("R6 byte read odd", v, 32'h5A);
    wr(8'h32, 2'd1, 1'b0, 32'hFFFF);
    rd(8'h32, 2'd1, v); chk("R6 unmapped write ignored", v, 32'h0);
    wr(8'h22, 2'd1, 1'b0, 32'h0702);
    rd(8'h22, 2'd1, v); chk("R6 control offset reads zero", v, 32'h0);

    // R9: display status sweep
    chk("R9 control outputs", {28'h0, cta_lock_o, sync_en_o, refresh_en_o, disp_en_o}, 32'hF);
    for (int s = 0; s < 64; s++) begin
      disp_stat_i = 6'(s);
      rd(8'h20, 2'd1, v);
      chk("R9 display status", v, 32'h0702 | 32'(s << 2));
    end
    disp_stat_i = '0;

    // R10: drawing control and status sweep
    wr(8'h42, 2'd1, 1'b0, 32'h1F02);
    chk("R10 sb_cmp_o", {27'h0, sb_cmp_o}, 32'h1F);
    chk("R10 draw_en_o", {31'h0, draw_en_o}, 32'h1);
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 16; f++) begin
        draw_stat_i = {f[3], c[4:0], f[2:0]};
        rd(8'h40, 2'd1, v);
        chk("R10 drawing status", v,
            32'(f[3]) << 15 | 32'(c) << 8 | 32'(f[2]) << 4 | 32'(f[1]) << 3 | 32'(f[0]) << 2 | 32'h2);
      end
    end
    draw_stat_i = '0;

    // R11: palettes
    wr(8'h62, 2'd1, 1'b0, 32'hFFFF);
    rd(8'h62, 2'd1, v);
    chk("R11 palette low bits zero", v, 32'hFC);
    chk("R11 bg_plt_o", {26'h0, bg_plt_o[11:6]}, 32'h3F);
    wr(8'h63, 2'd0, 1'b1, 32'h00);
    rd(8'h62, 2'd1, v);
    chk("R11 masked lower lane ignored", v, 32'hFC);
    wr(8'h63, 2'd0, 1'b0, 32'hFF);
    rd(8'h62, 2'd1, v);
    chk("R11 normal odd byte clears", v, 32'h0);

    // R7 / R8: interrupts
    wr(8'h02, 2'd1, 1'b0, 32'h0001);
    @(negedge clk_i); int_set_i = 16'h0001;
    @(negedge clk_i); int_set_i = 16'h0000;
    #1 chk("R8 irq not yet", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i); #1 chk("R8 irq one cycle later", {31'h0, irq_o}, 32'h1);
    rd(8'h00, 2'd1, v); chk("R7 pending set", v, 32'h1);
    wr(8'h04, 2'd1, 1'b0, 32'h0001);
    #1 chk("R8 irq held one cycle", {31'h0, irq_o}, 32'h1);
    @(negedge clk_i); #1 chk("R8 irq deasserts", {31'h0, irq_o}, 32'h0);
    rd(8'h00, 2'd1, v); chk("R7 pending cleared", v, 32'h0);
    @(negedge clk_i); int_set_i = 16'h0002;
    @(negedge clk_i); int_set_i = 16'h0000;
    repeat (2) @(negedge clk_i);
    #1 chk("R8 disabled source no irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; size_i = 2'd1; addr_i = 8'h04; wdata_i = 32'h0002; int_set_i = 16'h0002;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; int_set_i = 16'h0;
    rd(8'h00, 2'd1, v); chk("R7 set wins over clear", v, 32'h2);
    wr(8'h04, 2'd1, 1'b0, 32'hFFFF);
    rd(8'h00, 2'd1, v); chk("R7 clear all", v, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule